// File: doc/BRIEF.md
# Prioritised Status LED Blinker

This block drives one status LED from four active-low health indications and one user request. Each health indication is a fault level with a fixed rank. The block finds the highest-ranked level that is currently faulted and shows a repeating eight-slot blink pattern for that level. Each level's pattern lights a different number of leading slots, so an observer can tell the fault apart by counting the lit slots.

When no fault is present, the LED copies the user request. A free-running slot timer divides the system clock into slots of `SLOT_CLKS` cycles. The default is 12,500,000 cycles, which is 125 ms at 100 MHz.

The selection is a five-state machine. The states, from highest priority down, are:
- `SEL_PWR_FAULT`: power-good is low.
- `SEL_CFG_CLEAR`: configuration-clear is low.
- `SEL_POR_LOW`: power-on-reset is low.
- `SEL_NOT_DONE`: configuration-done is low.
- `SEL_USER`: no fault is present.

On every clock the machine moves from any state to the highest-priority state whose condition holds.
- If that target is the current state, the transition is a hold.
- Otherwise it is a level change. A level change restarts the slot timer, so the new pattern begins at its first slot.

Top module: `status_led_prio`

## Requirements
- R1: All five inputs pass through a two-flop synchroniser. A fault input change reaches the selection state on the third rising edge. A user-request change reaches `led_o` on the third rising edge.
- R2: With power-good low (priority 1), all 8 slots are lit, whatever the other inputs are.
- R3: With power-good high and configuration-clear low (priority 2), slots 0 to 4 are lit and slots 5 to 7 are dark.
- R4: With the two levels above clear and power-on-reset low (priority 3), slots 0 to 3 are lit and slots 4 to 7 are dark.
- R5: With the three levels above clear and configuration-done low (priority 4), slots 0 to 2 are lit and slots 3 to 7 are dark.
- R6: With every health input high, `led_o` follows `user_led_i`, and the blink pattern plays no part.
- R7: Each slot lasts `SLOT_CLKS` clock cycles. The slot index counts 0 to 7 and wraps, so a pattern repeats every 8 × `SLOT_CLKS` cycles.
- R8: A level change restarts the slot index and the slot timer at 0. For a fault level, `led_o` shows slot 0 (lit) on the fourth rising edge after the input change.
- R9: While `rst_ni` is low, `led_o` is 0, the selection is `SEL_PWR_FAULT` and the slot index is 0. This is because the synchroniser flops clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Power-good flag, low = fault (priority 1) |
| cfg_clear_ni | input | 1 | Configuration-clear status, low = fault (priority 2) |
| por_ni | input | 1 | Power-on-reset status, low = fault (priority 3) |
| cfg_done_i | input | 1 | Configuration-done flag, low = fault (priority 4) |
| user_led_i | input | 1 | User LED request, shown when no fault is present |
| led_o | output | 1 | LED drive, 1 = lit |

## Verification
A fault input change shows at `led_o` four rising edges after it is driven: two synchroniser flops, the state register, then the LED register. A user-request change shows three edges after it is driven, since it skips the state register. The bench drives inputs on falling edges. A reference model advances on rising edges through the same number of stages, and `led_o` is compared with it on every falling edge. Directed cases sample exactly on the edges named above, and one edge before them, to pin the latency of R1 and R8. A lit-slot count over one full pattern window pins R7.

// File: rtl/led_prio_pkg.sv
package led_prio_pkg;

    typedef enum logic [2:0] {
        SEL_PWR_FAULT = 3'd0,
        SEL_CFG_CLEAR = 3'd1,
        SEL_POR_LOW   = 3'd2,
        SEL_NOT_DONE  = 3'd3,
        SEL_USER      = 3'd4
    } led_sel_e;

    typedef struct packed {
        logic pwr_ok;
        logic cfg_clr_n;
        logic por_n;
        logic cfg_done;
        logic user;
    } led_status_t;

    localparam int unsigned STATUS_W = $bits(led_status_t);

endpackage

// File: rtl/led_sync2.sv
module led_sync2 #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= async_i[b];
                stage2_q <= stage1_q;
            end
        end
        assign sync_o[b] = stage2_q;
    end
endmodule

// File: rtl/led_prio_fsm.sv
module led_prio_fsm
    import led_prio_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned LIT_W = $clog2(SLOTS + 1)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  led_status_t st_i,
    output led_sel_e    sel_q_o,
    output logic        restart_o,
    output logic        pass_user_o,
    output logic [LIT_W-1:0] lit_cnt_o
);
    // Number of leading lit slots for each fault level, derived from SLOTS.
    localparam int unsigned LIT_PWR = SLOTS;
    localparam int unsigned LIT_CFG = SLOTS - 3;
    localparam int unsigned LIT_POR = SLOTS / 2;
    localparam int unsigned LIT_DONE = SLOTS - 5;

    led_sel_e state_q, state_d;

    // Next-state: the highest-ranked active fault wins from any state.
    always_comb begin
        if (!st_i.pwr_ok)         state_d = SEL_PWR_FAULT;
        else if (!st_i.cfg_clr_n) state_d = SEL_CFG_CLEAR;
        else if (!st_i.por_n)     state_d = SEL_POR_LOW;
        else if (!st_i.cfg_done)  state_d = SEL_NOT_DONE;
        else                      state_d = SEL_USER;
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEL_PWR_FAULT;
        else         state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        restart_o   = (state_d != state_q);
        pass_user_o = 1'b0;
        lit_cnt_o   = '0;
        unique case (state_q)
            SEL_PWR_FAULT: lit_cnt_o = LIT_W'(LIT_PWR);
            SEL_CFG_CLEAR: lit_cnt_o = LIT_W'(LIT_CFG);
            SEL_POR_LOW:   lit_cnt_o = LIT_W'(LIT_POR);
            SEL_NOT_DONE:  lit_cnt_o = LIT_W'(LIT_DONE);
            SEL_USER:      pass_user_o = 1'b1;
            default:       lit_cnt_o = LIT_W'(LIT_PWR);
        endcase
    end

    assign sel_q_o = state_q;
endmodule

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
    parameter int unsigned SLOT_CLKS = 12_500_000,
    parameter int unsigned SLOTS     = 8,
    localparam int unsigned CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [IDX_W-1:0] slot_idx_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             slot_end;

    assign slot_end = (cnt_q == CNT_W'(SLOT_CLKS - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (slot_end) begin
            cnt_q <= '0;
            idx_q <= (idx_q == IDX_W'(SLOTS - 1)) ? '0 : idx_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot_idx_o = idx_q;
endmodule

// File: rtl/status_led_prio.sv
module status_led_prio
    import led_prio_pkg::*;
#(
    parameter int unsigned SLOT_CLKS = 12_500_000,
    parameter int unsigned SLOTS     = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_ok_i,
    input  logic cfg_clear_ni,
    input  logic por_ni,
    input  logic cfg_done_i,
    input  logic user_led_i,
    output logic led_o
);
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned LIT_W = $clog2(SLOTS + 1);

    led_status_t          st_raw, st_s;
    led_sel_e             sel_q;
    logic                 restart;
    logic                 pass_user;
    logic [LIT_W-1:0]     lit_cnt;
    logic [IDX_W-1:0]     slot_idx;

    assign st_raw = '{pwr_ok: pwr_ok_i, cfg_clr_n: cfg_clear_ni, por_n: por_ni,
                      cfg_done: cfg_done_i, user: user_led_i};

    led_sync2 #(.WIDTH(STATUS_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (st_raw),
        .sync_o  (st_s)
    );

    led_prio_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .st_i        (st_s),
        .sel_q_o     (sel_q),
        .restart_o   (restart),
        .pass_user_o (pass_user),
        .lit_cnt_o   (lit_cnt)
    );

    led_slot_timer #(.SLOT_CLKS(SLOT_CLKS), .SLOTS(SLOTS)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart),
        .slot_idx_o (slot_idx)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        led_o <= 1'b0;
        else if (pass_user) led_o <= st_s.user;
        else                led_o <= ({1'b0, slot_idx} < (IDX_W + 1)'(lit_cnt));
    end
endmodule

// File: rtl/led_prio_chk.sv
module led_prio_chk
    import led_prio_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input led_sel_e         sel_q,
    input logic             restart,
    input logic [IDX_W-1:0] slot_idx,
    input logic             user_s,
    input logic             pwr_s,
    input logic             led_o
);
    AST_PWR_ALL_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q == SEL_PWR_FAULT |=> led_o); // R2

    AST_PWR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_s |=> sel_q == SEL_PWR_FAULT); // R2

    AST_CFG_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q == SEL_CFG_CLEAR |=> led_o == (int'($past(slot_idx)) < SLOTS - 3)); // R3

    AST_POR_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q == SEL_POR_LOW |=> led_o == (int'($past(slot_idx)) < SLOTS / 2)); // R4

    AST_DONE_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q == SEL_NOT_DONE |=> led_o == (int'($past(slot_idx)) < SLOTS - 5)); // R5

    AST_USER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q == SEL_USER |=> led_o == $past(user_s)); // R6

    AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !restart |=> (slot_idx == $past(slot_idx)) ||
                     (slot_idx == (($past(slot_idx) == IDX_W'(SLOTS - 1)) ? '0 : $past(slot_idx) + 1'b1))); // R7

    AST_RESTART_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart |=> slot_idx == '0); // R8

    AST_RESET_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !led_o && sel_q == SEL_PWR_FAULT); // R9
endmodule

bind status_led_prio led_prio_chk #(.SLOTS(SLOTS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_q    (sel_q),
    .restart  (restart),
    .slot_idx (slot_idx),
    .user_s   (st_s.user),
    .pwr_s    (st_s.pwr_ok),
    .led_o    (led_o)
);

// File: tb/test_status_led_prio.sv
module test_status_led_prio;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0, cfg_clr_n = 1'b0, por_n = 1'b0, done = 1'b0, user = 1'b0;
    logic led;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    status_led_prio #(.SLOT_CLKS(S), .SLOTS(8)) i_status_led_prio (
        .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .cfg_clear_ni(cfg_clr_n),
        .por_ni(por_n), .cfg_done_i(done), .user_led_i(user), .led_o(led)
    );

    // Level: 0 power, 1 cfg clear, 2 por, 3 done, 4 user.
    function automatic int pick(logic [4:0] v);
        if (!v[4]) return 0;
        if (!v[3]) return 1;
        if (!v[2]) return 2;
        if (!v[1]) return 3;
        return 4;
    endfunction

    function automatic int lit_of(int lvl);
        case (lvl)
            0: return 8;
            1: return 5;
            2: return 4;
            default: return 3;
        endcase
    endfunction

    function automatic string req_of(int lvl);
        case (lvl)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reference pipeline: two sync stages, level register, LED register.
    logic [4:0] m1 = '0, m2 = '0;
    int m_lvl = 0;
    int m_age = 0;
    logic m_led = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m_lvl <= 0; m_age <= 0; m_led <= 1'b0;
        end else begin
            m1 <= {pwr_ok, cfg_clr_n, por_n, done, user};
            m2 <= m1;
            m_lvl <= pick(m2);
            m_age <= (pick(m2) != m_lvl) ? 0 : m_age + 1;
            m_led <= (m_lvl == 4) ? m2[0] : (((m_age / S) % 8) < lit_of(m_lvl));
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (led !== m_led) begin
                errors++;
                $display("FAIL %s R7 model compare t=%0t actual=%0b expected=%0b",
                         req_of(m_lvl), $time, led, m_led);
            end
        end
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic setv(logic [4:0] v);
        {pwr_ok, cfg_clr_n, por_n, done, user} = v;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lit;
        void'($urandom(32'd4242));
        wait_n(3);
        check("R9", led, 1'b0);              // R9 reset: dark
        setv(5'b11110);
        wait_n(2);
        check("R9", led, 1'b0);
        rst_n = 1'b1;
        model_on = 1'b1;
        wait_n(30);

        // R1: user change reaches LED on the third edge, not the second.
        @(negedge clk); setv(5'b11111);
        wait_n(2); check("R1", led, 1'b0);
        wait_n(1); check("R1", led, 1'b1);
        @(negedge clk); setv(5'b11110);
        wait_n(10);

        // R8: fault level shows slot 0 on the fourth edge.
        setv(5'b11010);
        wait_n(3); check("R8", led, 1'b0);
        wait_n(1); check("R8", led, 1'b1);
        // R7/R4: one full pattern window has 4*S lit cycles, then dark at slot 4.
        lit = 1;
        for (int k = 1; k < 8 * S; k++) begin
            wait_n(1);
            if (k == 4 * S) check("R7", led, 1'b0);
            lit += int'(led);
        end
        checks++;
        if (lit != 4 * S) begin
            errors++;
            $display("FAIL R7 lit count actual=%0d expected=%0d", lit, 4 * S);
        end
        wait_n(1); check("R7", led, 1'b1);  // pattern repeats

        // Each level held long enough for its full pattern (R2..R5).
        setv(5'b01110); wait_n(40);
        setv(5'b10111); wait_n(40);
        setv(5'b11100); wait_n(40);
        // R8: change level mid-pattern, restart at slot 0.
        setv(5'b11010); wait_n(4 + 2 * S);
        setv(5'b10110); wait_n(40);

        // Constrained random phase.
        for (int i = 0; i < 300; i++) begin
            logic [4:0] v;
            v[4] = ($urandom_range(0, 7) != 0);
            v[3] = ($urandom_range(0, 3) != 0);
            v[2] = ($urandom_range(0, 3) != 0);
            v[1] = ($urandom_range(0, 3) != 0);
            v[0] = $urandom_range(0, 1);
            setv(v);
            wait_n($urandom_range(1, 40));
        end

        wait_n(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule